// File: doc/BRIEF.md
# Interrupt Mask Release Monitor

This block keeps one 32-bit message-interrupt mask for each of 32 functions and watches every write to those masks. When a write turns any mask bit of a function from 1 to 0, a sticky status bit dedicated to that function is raised, provided the detection enable input is high. Host software and local firmware share one mask write port, which carries a function index and the new 32-bit mask value. A combinational read port returns the stored mask of any function.

Firmware inspects the status vector and clears its bits by writing ones through a clear port. A single level-sensitive local interrupt is asserted while any status bit is set and not suppressed by its bit in the interrupt mask input, qualified by a global interrupt enable. The interrupt comes from a register, so it reacts one cycle after the status or the gating inputs change. It stays high until firmware clears the responsible status bits.

Top module: `msi_mask_clear_monitor`

## Requirements
- R1: After reset every function's mask reads back as 0xFFFFFFFF on `mrd_data`.
- R2: A write with `mwr_en` high stores `mwr_data` into the mask of function `mwr_fn`, and `mrd_data` shows it from the cycle after the write edge.
- R3: A write that changes at least one mask bit of function k from 1 to 0 while `fall_det_en` is 1 sets `status[k]` (bit k belongs to function index k) at the write edge.
- R4: A write that takes no mask bit from 1 to 0 (equal data, or only 0-to-1 changes) sets no status bit.
- R5: While `fall_det_en` is 0, falling mask bits set no status bit, but the mask is still updated.
- R6: With `sts_clr_en` high, each 1 in `sts_clr_bits` clears the matching status bit at the next edge; bits written 0 keep their value, and status bits never drop otherwise.
- R7: When a status bit is set and cleared in the same cycle, it ends up set.
- R8: Reset drives every status bit and `irq` to 0.
- R9: `irq` equals, one cycle later, `irq_en` AND the OR over k of (`status[k]` AND NOT `irq_mask[k]`); a 1 in `irq_mask[k]` suppresses function k.
- R10: Once asserted, `irq` stays high until the unmasked status bits are cleared or the gating inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mwr_en | input | 1 | Mask write strobe |
| mwr_fn | input | 5 | Function index of the mask write |
| mwr_data | input | 32 | New mask value |
| mrd_fn | input | 5 | Function index for mask readback |
| mrd_data | output | 32 | Stored mask of function `mrd_fn` |
| fall_det_en | input | 1 | Enables status setting on falling mask bits |
| sts_clr_en | input | 1 | Status clear strobe |
| sts_clr_bits | input | 32 | Write-one-to-clear pattern |
| status | output | 32 | Sticky per-function status vector |
| irq_mask | input | 32 | Per-function interrupt suppression, 1 = suppressed |
| irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Registered local interrupt |

## Verification
A mask write or a clear pattern applied before edge N shows in `status` and on the readback port right after edge N, while `irq` reflects the status and gating seen before edge N only after edge N+1. The driver applies stimulus at falling edges and, for every cycle, queues the expected status and interrupt tagged with the edge count at which they are due. The monitor compares at the following falling edge once the edge counter reaches that value, so each result is checked in exactly the cycle it becomes valid. Mask readback is compared combinationally after the select settles within the same low clock phase.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  localparam int unsigned DEF_NUM_FN = 32;
  localparam int unsigned DEF_MASK_W = 32;
endpackage

// File: rtl/mmc_mask_bank.sv
module mmc_mask_bank #(
  parameter int unsigned NUM_FN = 32,
  parameter int unsigned MASK_W = 32,
  parameter int unsigned IDX_W  = $clog2(NUM_FN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_fn,
  input  logic [MASK_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_fn,
  output logic [MASK_W-1:0] rd_mask,
  output logic [MASK_W-1:0] wr_old,
  output logic              wr_fell
);
  logic [MASK_W-1:0] mask_q [NUM_FN];
  logic [NUM_FN-1:0] we_vec;

  // per-function storage with reset to all ones
  for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
    assign we_vec[g] = wr_en && (wr_fn == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g] <= '1;
      end else if (we_vec[g]) begin
        mask_q[g] <= wr_data;
      end
    end
  end

  // old value of the function being written and readback selection
  always_comb begin
    wr_old  = '0;
    rd_mask = '0;
    for (int k = 0; k < NUM_FN; k++) begin
      if (wr_fn == IDX_W'(k)) wr_old  = mask_q[k];
      if (rd_fn == IDX_W'(k)) rd_mask = mask_q[k];
    end
  end

  // any bit going from 1 to 0 on this write
  assign wr_fell = wr_en && (|(wr_old & ~wr_data));
endmodule

// File: rtl/mmc_status.sv
module mmc_status #(
  parameter int unsigned NUM_FN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FN-1:0] set_vec,
  input  logic              clr_en,
  input  logic [NUM_FN-1:0] clr_bits,
  output logic [NUM_FN-1:0] sts
);
  logic [NUM_FN-1:0] sts_q;
  logic [NUM_FN-1:0] sts_d;
  logic [NUM_FN-1:0] clr_eff;
  logic              upd;

  always_comb begin
    clr_eff = clr_en ? clr_bits : '0;
    // set after clear: a new event is never lost
    sts_d   = (sts_q & ~clr_eff) | set_vec;
    upd     = clr_en || (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (upd) begin
      sts_q <= sts_d;
    end
  end

  assign sts = sts_q;
endmodule

// File: rtl/mmc_irq_gen.sv
module mmc_irq_gen #(
  parameter int unsigned NUM_FN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FN-1:0] sts,
  input  logic [NUM_FN-1:0] irq_mask,
  input  logic              irq_en,
  output logic              irq
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = irq_en && (|(sts & ~irq_mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/msi_mask_clear_monitor.sv
module msi_mask_clear_monitor
  import mmc_pkg::*;
#(
  parameter int unsigned NUM_FN = DEF_NUM_FN,
  parameter int unsigned MASK_W = DEF_MASK_W,
  localparam int unsigned IDX_W = $clog2(NUM_FN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mwr_en,
  input  logic [IDX_W-1:0]  mwr_fn,
  input  logic [MASK_W-1:0] mwr_data,
  input  logic [IDX_W-1:0]  mrd_fn,
  output logic [MASK_W-1:0] mrd_data,
  input  logic              fall_det_en,
  input  logic              sts_clr_en,
  input  logic [NUM_FN-1:0] sts_clr_bits,
  output logic [NUM_FN-1:0] status,
  input  logic [NUM_FN-1:0] irq_mask,
  input  logic              irq_en,
  output logic              irq
);
  logic [MASK_W-1:0] wr_old;
  logic              wr_fell;
  logic [NUM_FN-1:0] set_vec;

  mmc_mask_bank #(.NUM_FN(NUM_FN), .MASK_W(MASK_W), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mwr_en),
    .wr_fn   (mwr_fn),
    .wr_data (mwr_data),
    .rd_fn   (mrd_fn),
    .rd_mask (mrd_data),
    .wr_old  (wr_old),
    .wr_fell (wr_fell)
  );

  // route the detected fall to the status bit of the written function
  for (genvar g = 0; g < NUM_FN; g++) begin : g_set
    assign set_vec[g] = fall_det_en && wr_fell && (mwr_fn == IDX_W'(g));
  end

  mmc_status #(.NUM_FN(NUM_FN)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_en   (sts_clr_en),
    .clr_bits (sts_clr_bits),
    .sts      (status)
  );

  mmc_irq_gen #(.NUM_FN(NUM_FN)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sts      (status),
    .irq_mask (irq_mask),
    .irq_en   (irq_en),
    .irq      (irq)
  );
endmodule

// File: rtl/msi_mask_clear_monitor_chk.sv
module msi_mask_clear_monitor_chk #(
  parameter int unsigned NUM_FN = 32,
  parameter int unsigned MASK_W = 32,
  parameter int unsigned IDX_W  = $clog2(NUM_FN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_fn,
  input logic [MASK_W-1:0] wr_data,
  input logic [MASK_W-1:0] wr_old,
  input logic              det_en,
  input logic              clr_en,
  input logic [NUM_FN-1:0] clr_bits,
  input logic [NUM_FN-1:0] status,
  input logic [NUM_FN-1:0] irq_mask,
  input logic              irq_en,
  input logic              irq
);
  logic [IDX_W-1:0] fn_q;
  logic             fall_now;
  logic             pend_now;

  always_ff @(posedge clk) fn_q <= wr_fn;

  assign fall_now = wr_en && (|(wr_old & ~wr_data));
  assign pend_now = irq_en && (|(status & ~irq_mask));

  // R3 and R7: a detected fall sets its bit even with a same-cycle clear
  a_r3_fall_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_now && det_en) |=> status[fn_q]);

  a_r4_no_set_without_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_now |=> ((status & ~$past(status)) == '0));

  a_r5_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> ((status & ~$past(status)) == '0));

  a_r6_hold_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> (($past(status) & ~status) == '0));

  a_r6_clear_only_written_ones: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (($past(status) & ~status & ~$past(clr_bits)) == '0));

  a_r9_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    pend_now |=> irq);

  a_r10_irq_falls_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_now |=> !irq);
endmodule

bind msi_mask_clear_monitor msi_mask_clear_monitor_chk #(
  .NUM_FN(NUM_FN), .MASK_W(MASK_W), .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (mwr_en),
  .wr_fn    (mwr_fn),
  .wr_data  (mwr_data),
  .wr_old   (wr_old),
  .det_en   (fall_det_en),
  .clr_en   (sts_clr_en),
  .clr_bits (sts_clr_bits),
  .status   (status),
  .irq_mask (irq_mask),
  .irq_en   (irq_en),
  .irq      (irq)
);

// File: tb/sim_msi_mask_clear_monitor.sv
module sim_msi_mask_clear_monitor;
  logic        clk;
  logic        rst_n;
  logic        mwr_en;
  logic [4:0]  mwr_fn;
  logic [31:0] mwr_data;
  logic [4:0]  mrd_fn;
  logic [31:0] mrd_data;
  logic        fall_det_en;
  logic        sts_clr_en;
  logic [31:0] sts_clr_bits;
  logic [31:0] status;
  logic [31:0] irq_mask;
  logic        irq_en;
  logic        irq;

  msi_mask_clear_monitor u0 (
    .clk(clk), .rst_n(rst_n), .mwr_en(mwr_en), .mwr_fn(mwr_fn),
    .mwr_data(mwr_data), .mrd_fn(mrd_fn), .mrd_data(mrd_data),
    .fall_det_en(fall_det_en), .sts_clr_en(sts_clr_en),
    .sts_clr_bits(sts_clr_bits), .status(status), .irq_mask(irq_mask),
    .irq_en(irq_en), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int          due;
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t       sb[$];
  int          edges = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] m_mask [32];
  logic [31:0] m_sts;
  logic        done = 1'b0;

  always @(posedge clk) edges++;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compare queued expectations when their edge has passed
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb.size() > 0 && sb[0].due <= edges) begin
        item_t it;
        it = sb.pop_front();
        if (it.is_irq) check(it.req, "irq", {31'd0, irq}, it.exp);
        else           check(it.req, "status", status, it.exp);
      end
    end
  end

  // set inputs for one cycle and push the expected results
  task automatic apply(input bit we, input int fn, input logic [31:0] data,
                       input bit det, input bit ce, input logic [31:0] cb,
                       input string req);
    logic        fell;
    logic [31:0] nxt;
    logic        irq_exp;
    item_t       a;
    item_t       b;
    mwr_en = we; mwr_fn = 5'(fn); mwr_data = data;
    fall_det_en = det; sts_clr_en = ce; sts_clr_bits = cb;
    fell = 1'b0;
    if (we) begin
      fell = |(m_mask[fn] & ~data);
      m_mask[fn] = data;
    end
    irq_exp = irq_en && (|(m_sts & ~irq_mask));
    nxt = (m_sts & ~(ce ? cb : 32'd0));
    if (we && det && fell) nxt[fn] = 1'b1;
    m_sts = nxt;
    a.due = edges + 1; a.is_irq = 1'b0; a.exp = nxt;               a.req = req;
    b.due = edges + 1; b.is_irq = 1'b1; b.exp = {31'd0, irq_exp};  b.req = req;
    sb.push_back(a);
    sb.push_back(b);
  endtask

  task automatic drive(input bit we, input int fn, input logic [31:0] data,
                       input bit det, input bit ce, input logic [31:0] cb,
                       input string req);
    @(negedge clk);
    apply(we, fn, data, det, ce, cb, req);
  endtask

  task automatic idle(input int n, input bit det, input string req);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 32'd0, det, 1'b0, 32'd0, req);
  endtask

  task automatic chk_mask(input int fn, input logic [31:0] exp, input string req);
    @(negedge clk);
    apply(1'b0, 0, 32'd0, 1'b1, 1'b0, 32'd0, req);
    mrd_fn = 5'(fn);
    #1;
    check(req, "mask", mrd_data, exp);
  endtask

  initial begin
    rst_n = 1'b1;
    mwr_en = 1'b0; mwr_fn = '0; mwr_data = '0; mrd_fn = '0;
    fall_det_en = 1'b0; sts_clr_en = 1'b0; sts_clr_bits = '0;
    irq_mask = '0; irq_en = 1'b0;
    for (int i = 0; i < 32; i++) m_mask[i] = 32'hFFFF_FFFF;
    m_sts = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8 and R1: state held in reset
    check("R8", "status in reset", status, 32'd0);
    check("R8", "irq in reset", {31'd0, irq}, 32'd0);
    mrd_fn = 5'd17; #1;
    check("R1", "mask in reset", mrd_data, 32'hFFFF_FFFF);
    @(negedge clk);
    rst_n = 1'b1;
    irq_en = 1'b1;

    chk_mask(0, 32'hFFFF_FFFF, "R1");
    chk_mask(31, 32'hFFFF_FFFF, "R1");
    // R4: rewrite of all ones
    drive(1'b1, 3, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'd0, "R4");
    // R3: single bit falls on function 3
    drive(1'b1, 3, 32'hFFFF_FFFE, 1'b1, 1'b0, 32'd0, "R3");
    chk_mask(3, 32'hFFFF_FFFE, "R2");
    idle(4, 1'b1, "R10");
    // R4: only a 0-to-1 change
    drive(1'b1, 3, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'd0, "R4");
    // R6: clear pattern of zeros keeps the bit, then a one clears it
    drive(1'b0, 0, 32'd0, 1'b1, 1'b1, 32'd0, "R6");
    drive(1'b0, 0, 32'd0, 1'b1, 1'b1, 32'h0000_0008, "R6");
    idle(2, 1'b1, "R10");
    // R5: falls ignored while detection is off, mask still updated
    drive(1'b1, 0, 32'd0, 1'b0, 1'b0, 32'd0, "R5");
    chk_mask(0, 32'd0, "R5");
    // R4: function 0 already zero, no fall
    drive(1'b1, 0, 32'd0, 1'b1, 1'b0, 32'd0, "R4");
    // R3: top function maps to bit 31
    drive(1'b1, 31, 32'h7FFF_FFFF, 1'b1, 1'b0, 32'd0, "R3");
    idle(2, 1'b1, "R10");
    // R9: suppress via per-bit mask, then via global enable
    @(negedge clk); irq_mask = 32'h8000_0000;
    apply(1'b0, 0, 32'd0, 1'b1, 1'b0, 32'd0, "R9");
    idle(2, 1'b1, "R9");
    @(negedge clk); irq_mask = 32'd0; irq_en = 1'b0;
    apply(1'b0, 0, 32'd0, 1'b1, 1'b0, 32'd0, "R9");
    idle(2, 1'b1, "R9");
    @(negedge clk); irq_en = 1'b1;
    apply(1'b0, 0, 32'd0, 1'b1, 1'b0, 32'd0, "R9");
    // R7: set and clear of bit 5 together, bit 31 cleared at once
    drive(1'b1, 5, 32'hFFF0_FFFF, 1'b1, 1'b1, 32'h8000_0020, "R7");
    idle(2, 1'b1, "R7");
    drive(1'b0, 0, 32'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R6");
    idle(2, 1'b1, "R10");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom_range(0, 2) == 0) d = d | 32'hFFFF_0000;
      @(negedge clk);
      if ($urandom_range(0, 15) == 0) irq_mask = $urandom;
      if ($urandom_range(0, 31) == 0) irq_en = ~irq_en;
      apply($urandom_range(0, 1) == 1, int'($urandom_range(0, 31)), d,
            $urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0,
            $urandom, "R3");
    end
    for (int i = 0; i < 32; i++) chk_mask(i, m_mask[i], "R2");
    idle(3, 1'b1, "R6");
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule